// File: doc/BRIEF.md
# Line fetch address generator

This block sequences the per-line read requests of a display controller over one frame scan. A start pulse, accepted only while the controller is both enabled and powered, captures the frame base address, the line width in pixels, the line count and the pixel depth code. The block then issues one request per display line. Each request carries a start address and a byte length. Requests leave the block through a valid/ready handshake.

The byte length of a line follows from the pixel count and the depth code. The count is shifted right for the sub-byte depths and shifted left for the wide depths. The first line starts at the captured base address. Each following line starts one line length further on. After the last request is accepted, a single-cycle done pulse follows. If the enable or the power is dropped mid-frame, the block lets the pending request finish its handshake and then stops without a done pulse.

Top module: `line_fetch_gen`

## Requirements
- R1: After reset, `req_valid_o` and `done_o` are low.
- R2: `req_len_o` equals the captured pixel count shifted by the depth code. Code 0 shifts right by 3, code 1 right by 2, code 2 right by 1, code 3 leaves it unchanged, code 4 shifts left by 1 and code 5 shifts left by 2.
- R3: The first request of a frame carries the captured base address.
- R4: Each later request carries the previous request's address plus `req_len_o`, modulo 2^ADDR_W.
- R5: A frame that is not aborted issues exactly `lines_i`+1 requests.
- R6: `start_i` is ignored unless `enable_i` and `power_i` are both high and `bpp_i` is 0 to 5. Codes 6 and 7 start nothing.
- R7: `start_i` is ignored while a request is valid. Base, width, line count and depth are sampled only on an accepted start, so changing them mid-frame has no effect.
- R8: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o`, `req_addr_o` and `req_len_o` hold their values on the next cycle.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final request is accepted, and `req_valid_o` is low in that cycle.
- R10: If `enable_i` or `power_i` is low when a request is accepted, no further request follows in that frame and no done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable |
| power_i | input | 1 | Panel power |
| start_i | input | 1 | Frame start pulse |
| base_addr_i | input | ADDR_W | Frame base byte address |
| width_px_i | input | PIX_W | Pixels per line |
| lines_i | input | LINE_W | Lines per frame minus one |
| bpp_i | input | 3 | Pixel depth code |
| req_valid_o | output | 1 | Line request valid |
| req_ready_i | input | 1 | Line request accepted when high with valid |
| req_addr_o | output | ADDR_W | Line start byte address |
| req_len_o | output | PIX_W+2 | Line length in bytes |
| done_o | output | 1 | Frame complete pulse |

## Verification
The hardest situation to reach is an abort while a request is stalled. The bench holds ready low to park a request, drops the enable while the request waits, and keeps it waiting for several cycles. It then releases ready and confirms that the stalled request stays unchanged, that one acceptance ends the frame, and that no done pulse appears. Restarting during a stalled frame and changing the sampled inputs mid-frame are driven the same way, with a pseudo-random ready pattern.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  localparam logic [2:0] BPP_1  = 3'd0;
  localparam logic [2:0] BPP_2  = 3'd1;
  localparam logic [2:0] BPP_4  = 3'd2;
  localparam logic [2:0] BPP_8  = 3'd3;
  localparam logic [2:0] BPP_16 = 3'd4;
  localparam logic [2:0] BPP_32 = 3'd5;

  function automatic logic bpp_legal(logic [2:0] code);
    return code <= BPP_32;
  endfunction
endpackage

// File: rtl/lfg_stride.sv
module lfg_stride import lfg_pkg::*; #(
  parameter int PIX_W = 12,
  localparam int LEN_W = PIX_W + 2
) (
  input  logic [PIX_W-1:0] px_i,
  input  logic [2:0]       bpp_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] px_ext;
  assign px_ext = {2'b00, px_i};

  always_comb begin
    unique case (bpp_i)
      BPP_1:   len_o = px_ext >> 3;
      BPP_2:   len_o = px_ext >> 2;
      BPP_4:   len_o = px_ext >> 1;
      BPP_8:   len_o = px_ext;
      BPP_16:  len_o = px_ext << 1;
      BPP_32:  len_o = px_ext << 2;
      default: len_o = '0;
    endcase
  end
endmodule

// File: rtl/lfg_line_ctr.sv
module lfg_line_ctr #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic              step_i,
  output logic              last_o
);
  logic [LINE_W:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= {1'b0, lines_i} + 1'b1;
    else if (step_i) left_q <= left_q - 1'b1;
  end

  assign last_o = (left_q == 1);

  // R5
  no_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> left_q > 1);
endmodule

// File: rtl/lfg_addr_acc.sv
module lfg_addr_acc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  stride_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= addr_o + ADDR_W'(stride_i);
  end

  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> addr_o == $past(addr_o) + ADDR_W'($past(stride_i)));
  // R3
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(base_i));
endmodule

// File: rtl/line_fetch_gen.sv
module line_fetch_gen import lfg_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10,
  localparam int LEN_W = PIX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              power_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [PIX_W-1:0]  width_px_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [2:0]        bpp_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              done_o
);
  logic             run_ok, go, hs, last, step;
  logic [LEN_W-1:0] len_d;

  assign run_ok = enable_i && power_i;
  assign go     = !req_valid_o && start_i && run_ok && bpp_legal(bpp_i);
  assign hs     = req_valid_o && req_ready_i;
  assign step   = hs && run_ok && !last;

  lfg_stride #(.PIX_W(PIX_W)) i_stride (
    .px_i (width_px_i),
    .bpp_i(bpp_i),
    .len_o(len_d)
  );

  lfg_line_ctr #(.LINE_W(LINE_W)) i_line_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .lines_i(lines_i),
    .step_i (step),
    .last_o (last)
  );

  lfg_addr_acc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_addr_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (go),
    .base_i  (base_addr_i),
    .step_i  (step),
    .stride_i(req_len_o),
    .addr_o  (req_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_len_o   <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= hs && run_ok && last;
      if (go) begin
        req_valid_o <= 1'b1;
        req_len_o   <= len_d;
      end else if (hs && (!run_ok || last)) begin
        req_valid_o <= 1'b0;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));
  // R9
  done_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(hs) && !req_valid_o);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  start_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(enable_i && power_i && start_i));
  // R10
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !run_ok |=> !req_valid_o && !done_o);
endmodule

// File: tb/test_line_fetch_gen.sv
module test_line_fetch_gen;
  localparam int ADDR_W = 32, PIX_W = 12, LINE_W = 10, LEN_W = PIX_W + 2;

  logic clk = 0, rst_n = 0;
  logic enable = 0, power = 0, start = 0, ready = 0;
  logic [ADDR_W-1:0] base = '0;
  logic [PIX_W-1:0]  width = '0;
  logic [LINE_W-1:0] lines = '0;
  logic [2:0]        bpp = '0;
  logic              valid, done;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  len;

  always #10 clk = ~clk;

  line_fetch_gen #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) i_line_fetch_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .power_i(power), .start_i(start),
    .base_addr_i(base), .width_px_i(width), .lines_i(lines), .bpp_i(bpp),
    .req_valid_o(valid), .req_ready_i(ready), .req_addr_o(addr), .req_len_o(len),
    .done_o(done));

  int checks = 0, fails = 0, cycles = 0, ready_mode = 0, accepts = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  bit m_valid = 0, m_done = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  int m_len = 0, m_left = 0;

  function automatic int exp_len(int w, int b);
    case (b)
      0: return w / 8;
      1: return w / 4;
      2: return w / 2;
      3: return w;
      4: return w * 2;
      default: return w * 4;
    endcase
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_done = 0; m_addr = '0; m_len = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (!m_valid) begin
        if (start && enable && power && bpp <= 5) begin
          m_valid = 1; m_addr = base; m_len = exp_len(int'(width), int'(bpp));
          m_left = int'(lines) + 1;
        end
      end else if (ready) begin
        accepts++;
        if (!(enable && power)) m_valid = 0;
        else if (m_left == 1) begin m_valid = 0; m_done = 1; end
        else begin m_addr = m_addr + ADDR_W'(m_len); m_left--; end
      end
    end
  end

  task automatic check(string t, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check(tag, "valid", valid, m_valid);
    check(tag == "R10" ? "R10" : "R9", "done", done, m_done);
    if (m_valid) begin
      check(tag == "R2" ? "R2" : "R3/R4", "addr", addr, m_addr);
      check("R2", "len", len, m_len);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic setup(logic [ADDR_W-1:0] b, int w, int l, int p);
    base = b; width = PIX_W'(w); lines = LINE_W'(l); bpp = 3'(p);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (m_valid) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic frame(string t, logic [ADDR_W-1:0] b, int w, int l, int p);
    int a0;
    tag = t;
    setup(b, w, l, p);
    a0 = accepts;
    pulse_start();
    wait_idle();
    if (p <= 5) check("R5", "requests", accepts - a0, l + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset valid", valid, 0);
    check("R1", "reset done", done, 0);
    rst_n = 1;
    // R6: disabled or unpowered start
    tag = "R6"; setup(32'h1000, 64, 3, 3);
    pulse_start(); repeat (3) @(negedge clk);
    enable = 1; pulse_start(); repeat (3) @(negedge clk);
    enable = 0; power = 1; pulse_start(); repeat (3) @(negedge clk);
    check("R6", "no request when gated", valid, 0);
    enable = 1;
    frame("R6", 32'h2000, 64, 2, 6);
    frame("R6", 32'h2000, 64, 2, 7);
    check("R6", "illegal bpp idle", valid, 0);
    // R2/R3/R4/R5 every depth, ready always high
    for (int p = 0; p < 6; p++) frame("R2", 32'h0001_0000 + p * 32'h100, 320, 4, p);
    frame("R5", 32'h8000_0000, 100, 0, 3);
    frame("R4", 32'hFFFF_FF00, 4095, 3, 5);
    // R8 random stalls
    ready_mode = 1;
    for (int p = 0; p < 6; p++) frame("R8", 32'h4000 + p, 200 + p * 8, 6, p);
    // R7 restart and input changes mid-frame
    tag = "R7"; setup(32'h5000, 160, 7, 4);
    pulse_start();
    repeat (4) @(negedge clk);
    setup(32'h9999_0000, 12, 1, 0);
    pulse_start();
    wait_idle();
    // R10 abort while stalled
    ready_mode = 2; tag = "R10"; setup(32'h6000, 64, 9, 3);
    pulse_start();
    repeat (3) @(negedge clk);
    enable = 0;
    repeat (4) @(negedge clk);
    check("R10", "stalled req held", valid, 1);
    ready_mode = 0;
    repeat (4) @(negedge clk);
    check("R10", "stopped after abort", valid, 0);
    enable = 1;
    // R9 back-to-back frames
    frame("R9", 32'h7000, 32, 1, 2);
    frame("R9", 32'h7100, 32, 2, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule